// File: doc/BRIEF.md
# Timer Prescaler and Interrupt Enable Control

This block sits beside a 16-bit free-running timer. It holds one 8-bit control register with four interrupt-enable bits and a two-bit divide select. From the system clock it makes a single-cycle tick enable at one of four ratios. That tick advances the free-running counter, which lives outside this block. The four enable bits are ANDed bit for bit with four status flags held in a separate flag register. The result drives one registered interrupt request.

The divide select is protected so that it can be set only during start-up. In normal mode it takes exactly one write, and that write must land inside a fixed window of clock edges after reset is released. In special mode, meant for test, the select field can be rewritten at any time. Whenever an accepted write changes the ratio, the divider restarts from zero, so the first tick at the new ratio comes one full period after the write.

Top module: `tmr_presc_ctl`

## Requirements
- R1: The control register is read and written at address REG_ADDR (default 0x24). Its bit 7 enables timer overflow, bit 6 enables real-time, bit 5 enables accumulator overflow, bit 4 enables accumulator edge, and bits 1:0 hold the divide select. Reads at any other address return 0, and writes to any other address change nothing.
- R2: Bits 3 and 2 always read as 0, and values written to them have no effect.
- R3: While reset is asserted and right after it is released, the register reads 0x00, irq_o is 0 and the divide ratio is 1, so tick_o is high every cycle.
- R4: The divide select maps 00 to 1, 01 to 4, 10 to 8 and 11 to 16. For a ratio N, tick_o is high for exactly one cycle out of every N.
- R5: In normal mode the first write to the register closes the divide select for good, even when the value written equals the current one. After that, further writes leave the field unchanged.
- R6: The clock edges after reset release are numbered from 0. In normal mode, a divide select write on edge WINDOW-1 (default 63) is accepted, and one on edge WINDOW or later is ignored.
- R7: In special mode every write updates the divide select, at any time and any number of times.
- R8: Bits 7:4 take the written value on every register write, in both modes, before and after the divide select is closed.
- R9: flg_i[k] is the flag at register bit k+4. irq_o goes high one cycle after some enable bit and its matching flag are both 1, and goes low one cycle after no such pair remains.
- R10: An accepted write that changes the divide select restarts the divider. With new ratio N, tick_o first rises on the (N-1)th cycle after the write edge, so for N = 1 it is high at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Register address |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr, combinational |
| special_mode | input | 1 | 1 = special mode, 0 = normal mode |
| flg_i | input | 4 | Status flags, bit k matching register bit k+4 |
| tick_o | output | 1 | Counter advance enable |
| irq_o | output | 1 | Registered interrupt request |

## Verification
The bench builds the block with its default parameters: a 64-edge write window, a 6-bit address and the register at 0x24. With a 64-edge window, the bench can land writes on both sides of the boundary, at edge 63 and edge 64, within a few dozen cycles of each reset. Because the largest ratio is only 16, many full divide periods and the restart delay after every ratio change fit into short runs. The bench uses separate resets to cover the early write, the boundary write, the late write and repeated rewrites in special mode.

// File: rtl/tmr_presc_pkg.sv
package tmr_presc_pkg;
  localparam int DATA_W = 8;
  localparam int EN_W   = 4;
  localparam int SEL_W  = 2;
  localparam int PCNT_W = 4;

  typedef logic [SEL_W-1:0] psel_t;

  typedef struct packed {
    logic [EN_W-1:0] en;
    logic [1:0]      rsvd;
    psel_t           sel;
  } ctl_reg_t;

  // divide ratio: 1 for select 0, otherwise 2^(select+1)
  function automatic logic [PCNT_W:0] div_ratio(psel_t s);
    logic [PCNT_W:0] r;
    if (s == '0) r = (PCNT_W+1)'(1);
    else         r = (PCNT_W+1)'(1) << (int'(s) + 1);
    return r;
  endfunction

  // terminal count of the prescale counter for a select value
  function automatic logic [PCNT_W-1:0] last_count(psel_t s);
    logic [PCNT_W:0] r;
    r = div_ratio(s) - (PCNT_W+1)'(1);
    return r[PCNT_W-1:0];
  endfunction

  function automatic ctl_reg_t reg_view(logic [EN_W-1:0] en, psel_t sel);
    ctl_reg_t v;
    v.en   = en;
    v.rsvd = '0;
    v.sel  = sel;
    return v;
  endfunction
endpackage

// File: rtl/tmr_presc_regs.sv
module tmr_presc_regs
  import tmr_presc_pkg::*;
#(
  parameter int              ADDR_W   = 6,
  parameter logic [ADDR_W-1:0] REG_ADDR = ADDR_W'('h24),
  parameter int              WINDOW   = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              special_mode,
  output logic [EN_W-1:0]   en_o,
  output psel_t             sel_o,
  output logic              sel_load_o,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int WC_W = $clog2(WINDOW + 1);

  logic [WC_W-1:0] win_cnt;
  logic            lock_q;
  logic [EN_W-1:0] en_q;
  psel_t           sel_q;
  ctl_reg_t        wr_view;

  // named internal events
  logic  addr_hit;
  logic  wr_hit;
  logic  win_open;
  logic  sel_ok;
  logic  sel_load;
  psel_t sel_new;

  assign wr_view  = ctl_reg_t'(bus_wdata);
  assign sel_new  = wr_view.sel;
  assign addr_hit = (bus_addr == REG_ADDR);
  assign wr_hit   = bus_we && addr_hit;
  assign win_open = (win_cnt < WC_W'(WINDOW));
  assign sel_ok   = special_mode || (!lock_q && win_open);
  assign sel_load = wr_hit && sel_ok && (sel_new != sel_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_cnt <= '0;
      lock_q  <= 1'b0;
      en_q    <= '0;
      sel_q   <= '0;
    end else begin
      if (win_open) win_cnt <= win_cnt + WC_W'(1);
      if (wr_hit) begin
        lock_q <= 1'b1;
        en_q   <= wr_view.en;
      end
      if (sel_load) sel_q <= sel_new;
    end
  end

  assign en_o       = en_q;
  assign sel_o      = sel_q;
  assign sel_load_o = sel_load;
  assign rdata_o    = addr_hit ? DATA_W'(reg_view(en_q, sel_q)) : '0;

  assert_lock_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_q && !special_mode) |=> $stable(sel_q));

  assert_window_shut_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!win_open && !special_mode) |=> $stable(sel_q));

  assert_window_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    win_cnt <= WC_W'(WINDOW));

  assert_special_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && special_mode) |=> (sel_q == $past(bus_wdata[1:0])));

  assert_enable_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit |=> (en_q == $past(bus_wdata[7:4])));

  assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rdata_o[3:2] == 2'b00);
endmodule

// File: rtl/tmr_presc_div.sv
module tmr_presc_div
  import tmr_presc_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  psel_t sel_i,
  input  logic  load_i,
  output logic  tick_o
);
  logic [PCNT_W-1:0] pcnt;
  logic [PCNT_W-1:0] last;
  logic              at_last;

  assign last    = last_count(sel_i);
  assign at_last = (pcnt == last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pcnt <= '0;
    else if (load_i)  pcnt <= '0;
    else if (at_last) pcnt <= '0;
    else              pcnt <= pcnt + PCNT_W'(1);
  end

  assign tick_o = at_last;

  assert_restart_R10: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (pcnt == '0));

  assert_tick_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_o && (last != '0) && !load_i) |=> !tick_o);

  assert_count_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pcnt <= last);
endmodule

// File: rtl/tmr_presc_irq.sv
module tmr_presc_irq
  import tmr_presc_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [EN_W-1:0] en_i,
  input  logic [EN_W-1:0] flg_i,
  output logic            irq_o
);
  logic [EN_W-1:0] armed;
  logic            req_now;
  logic            irq_q;

  for (genvar k = 0; k < EN_W; k++) begin : g_arm
    assign armed[k] = en_i[k] & flg_i[k];
  end

  assign req_now = |armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= req_now;
  end

  assign irq_o = irq_q;

  assert_irq_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (|(en_i & flg_i)) |=> irq_o);

  assert_irq_fall_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(en_i & flg_i)) |=> !irq_o);
endmodule

// File: rtl/tmr_presc_ctl.sv
module tmr_presc_ctl
  import tmr_presc_pkg::*;
#(
  parameter int                ADDR_W   = 6,
  parameter logic [ADDR_W-1:0] REG_ADDR = ADDR_W'('h24),
  parameter int                WINDOW   = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic              special_mode,
  input  logic [3:0]        flg_i,
  output logic              tick_o,
  output logic              irq_o
);
  logic [EN_W-1:0] en;
  psel_t           sel;
  logic            sel_load;

  tmr_presc_regs #(
    .ADDR_W  (ADDR_W),
    .REG_ADDR(REG_ADDR),
    .WINDOW  (WINDOW)
  ) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_addr    (bus_addr),
    .bus_we      (bus_we),
    .bus_wdata   (bus_wdata),
    .special_mode(special_mode),
    .en_o        (en),
    .sel_o       (sel),
    .sel_load_o  (sel_load),
    .rdata_o     (bus_rdata)
  );

  tmr_presc_div u_div (
    .clk   (clk),
    .rst_n (rst_n),
    .sel_i (sel),
    .load_i(sel_load),
    .tick_o(tick_o)
  );

  tmr_presc_irq u_irq (
    .clk  (clk),
    .rst_n(rst_n),
    .en_i (en),
    .flg_i(flg_i),
    .irq_o(irq_o)
  );

  assert_reset_state_R3: assert property (@(posedge clk)
    !rst_n |-> (bus_rdata == 8'h00 && !irq_o));
endmodule

// File: tb/test_tmr_presc_ctl.sv
module test_tmr_presc_ctl;
  localparam int CLK_PERIOD = 10;
  localparam int WIN        = 64;
  localparam logic [5:0] RA = 6'h24;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [5:0] bus_addr = RA;
  logic       bus_we = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       special_mode = 1'b0;
  logic [3:0] flg_i = 4'h0;
  logic       tick_o;
  logic       irq_o;

  int total = 0;
  int bad = 0;
  int ecnt = 0;
  int wd = 0;
  bit done = 0;

  // reference model state
  int m_en, m_sel, m_pc;
  bit m_lock, m_irq;

  tmr_presc_ctl i_tmr_presc_ctl (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .special_mode(special_mode),
    .flg_i(flg_i), .tick_o(tick_o), .irq_o(irq_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int b_ratio(int s);
    case (s)
      0: return 1;
      1: return 4;
      2: return 8;
      default: return 16;
    endcase
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  // behavioural reference
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ecnt = 0; m_en = 0; m_sel = 0; m_pc = 0; m_lock = 0; m_irq = 0;
    end else begin
      int old_en;
      bit restart;
      old_en  = m_en;
      restart = 0;
      if (bus_we && bus_addr == RA) begin
        m_en = bus_wdata[7:4];
        if (special_mode || (!m_lock && ecnt < WIN)) begin
          if (int'(bus_wdata[1:0]) != m_sel) begin
            m_sel = bus_wdata[1:0];
            restart = 1;
          end
        end
        m_lock = 1;
      end
      if (restart) m_pc = 0;
      else m_pc = (m_pc + 1) % b_ratio(m_sel);
      m_irq = ((old_en & int'(flg_i)) != 0);
      ecnt++;
    end
  end

  // cycle compare
  always @(negedge clk) begin
    if (rst_n && !done) begin
      int exp_rd;
      exp_rd = (bus_addr == RA) ? ((m_en << 4) | m_sel) : 0;
      chk(bus_rdata == 8'(exp_rd), "R1 register read", bus_rdata, exp_rd);
      chk(tick_o == (m_pc == b_ratio(m_sel) - 1), "R4 tick", tick_o, m_pc == b_ratio(m_sel) - 1);
      chk(irq_o == m_irq, "R9 irq", irq_o, m_irq);
    end
  end

  always @(posedge clk) begin
    wd++;
    if (wd > 20000 && !done) begin
      chk(0, "watchdog", wd, 20000);
      finish_run();
    end
  end

  task automatic do_reset(bit spec);
    @(negedge clk);
    rst_n = 0; bus_we = 0; flg_i = 0; bus_addr = RA; special_mode = spec;
    repeat (3) @(negedge clk);
    chk(bus_rdata == 8'h00, "R3 reset read", bus_rdata, 0);
    chk(irq_o == 1'b0, "R3 reset irq", irq_o, 0);
    rst_n = 1;
  endtask

  task automatic wr(logic [7:0] d);
    bus_addr = RA; bus_wdata = d; bus_we = 1;
    @(posedge clk);
    @(negedge clk);
    bus_we = 0;
  endtask

  task automatic tick_gap(int exp, string tag);
    int k = 0;
    while (!tick_o && k < 40) begin
      @(negedge clk);
      k++;
    end
    chk(k == exp, tag, k, exp);
  endtask

  initial begin
    // phase A: normal mode, early writes
    do_reset(0);
    @(negedge clk);
    chk(bus_rdata == 8'h00 && tick_o == 1'b1, "R3 after release", {bus_rdata, tick_o}, 1);
    wr(8'hFF);
    chk(bus_rdata == 8'hF3, "R1 R2 first write", bus_rdata, 8'hF3);
    wr(8'h51);
    chk(bus_rdata == 8'h53, "R5 select held after first write", bus_rdata, 8'h53);
    repeat (40) @(negedge clk);
    wr(8'h80);
    chk(bus_rdata == 8'h83, "R8 enables after lock", bus_rdata, 8'h83);
    flg_i = 4'b1000;
    chk(irq_o == 1'b0, "R9 no same-cycle irq", irq_o, 0);
    @(negedge clk);
    chk(irq_o == 1'b1, "R9 irq one cycle later", irq_o, 1);
    flg_i = 4'b0111;
    @(negedge clk);
    chk(irq_o == 1'b0, "R9 unmatched flags", irq_o, 0);
    bus_addr = 6'h10; bus_wdata = 8'h00; bus_we = 1;
    @(negedge clk);
    bus_we = 0;
    chk(bus_rdata == 8'h00, "R1 other address reads 0", bus_rdata, 0);
    bus_addr = RA;
    @(negedge clk);
    chk(bus_rdata == 8'h83, "R1 other address write ignored", bus_rdata, 8'h83);
    wr(8'h0C);
    chk(bus_rdata == 8'h03, "R2 reserved bits stay 0", bus_rdata, 8'h03);

    // phase B: write on the last edge of the window
    do_reset(0);
    while (ecnt != WIN - 1) @(negedge clk);
    wr(8'h02);
    chk(bus_rdata == 8'h02, "R6 edge 63 accepted", bus_rdata, 8'h02);
    tick_gap(7, "R10 restart after accepted write");

    // phase C: write on the first edge after the window
    do_reset(0);
    while (ecnt != WIN) @(negedge clk);
    wr(8'h03);
    chk(bus_rdata == 8'h00, "R6 edge 64 rejected", bus_rdata, 8'h00);
    wr(8'h30);
    chk(bus_rdata == 8'h30, "R8 enables after window", bus_rdata, 8'h30);

    // phase D: special mode rewrites
    do_reset(1);
    repeat (80) @(negedge clk);
    wr(8'h01);
    chk(bus_rdata == 8'h01, "R7 special write 1", bus_rdata, 8'h01);
    tick_gap(3, "R10 gap ratio 4");
    wr(8'h03);
    chk(bus_rdata == 8'h03, "R7 special write 2", bus_rdata, 8'h03);
    tick_gap(15, "R10 gap ratio 16");
    wr(8'h02);
    chk(bus_rdata == 8'h02, "R7 special write 3", bus_rdata, 8'h02);
    tick_gap(7, "R10 gap ratio 8");
    begin
      int n = 0;
      for (int i = 0; i < 32; i++) begin
        @(negedge clk);
        if (tick_o) n++;
      end
      chk(n == 4, "R4 ticks in 32 cycles at ratio 8", n, 4);
    end
    wr(8'h00);
    chk(bus_rdata == 8'h00 && tick_o == 1'b1, "R10 ratio 1 immediate", {bus_rdata, tick_o}, 1);
    repeat (5) @(negedge clk);
    finish_run();
  end
endmodule